// File: doc/BRIEF.md
# Synchronous Dual-Port RAM with Selectable Read Path

This block is a true dual-port static RAM. It has two independent access ports, called left and right, and both run on one shared clock. Each port has its own address, write data, a read/write select (`rnw`), an active-low and an active-high port enable, and an active-low output enable. Read data leaves each port as a data bus plus a drive flag. The drive flag stands in for a three-state pad, so the block stays synthesizable. While a port does not drive, its data bus reads as zero.

A static input, `pipe_mode`, chooses the read path for both ports.
- **Flow-through** (`pipe_mode`=0): the word read at a clock edge appears right after that edge.
- **Pipelined** (`pipe_mode`=1): the word passes through one more register and appears one clock later.

A port counts as selected only when its active-low enable is low and its active-high enable is high. Any clock edge at which a port is not selected puts that port into power-down. In pipelined mode, the first read after power-down only re-arms the port, and it produces no output.

Both ports may reach the same word in the same cycle. A read returns the contents from before any write at the same edge. When both ports write one address together, the left port's data is stored. `pipe_mode` is held static and changed only while reset is asserted.

Top module: `dpsram_core`

## Requirements
- R1: A port is selected at a rising edge only when `en_n`=0 and `en`=1. At an edge where the port is not selected, no write takes place and no read result is produced: in the output slot belonging to that edge, `drive` is 0.
- R2: At a rising edge where the port is selected and `rnw`=0, `wdata` is stored at `addr`.
- R3: In flow-through mode (`pipe_mode`=0), a selected read (`rnw`=1) at edge k sets `drive`=1 and `rdata` to the word at `addr` from just after edge k until edge k+1, provided `oe_n`=0.
- R4: In pipelined mode (`pipe_mode`=1), a selected read at edge k is shown from just after edge k+1 until edge k+2, provided `oe_n`=0 and the port was selected at edge k-1.
- R5: `oe_n`=1 forces `drive` to 0 at once, without waiting for a clock edge. Returning `oe_n` to 0 restores the pending read result at once.
- R6: In pipelined mode, a read at edge k, when the port was not selected at edge k-1, yields `drive`=0 in its output slot. This includes the first edge after reset.
- R7: A write cycle yields `drive`=0 in its output slot, in either mode, so a read that follows a write leaves a one-slot gap on the output.
- R8: When one port reads the address that the other port writes at the same edge, the read returns the earlier contents. A read of that address at a later edge returns the new data.
- R9: When both ports write the same address at the same edge, the left port's data is stored.
- R10: While `rst_n`=0, and just after it is released, both `drive` outputs are 0.
- R11: While `drive`=0, `rdata` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| pipe_mode | input | 1 | 0 = flow-through read path, 1 = pipelined read path |
| l_addr | input | ADDR_W | Left port word address |
| l_wdata | input | DATA_W | Left port write data |
| l_rnw | input | 1 | Left port: 1 = read, 0 = write |
| l_en_n | input | 1 | Left port active-low enable |
| l_en | input | 1 | Left port active-high enable |
| l_oe_n | input | 1 | Left port active-low output enable (asynchronous) |
| l_rdata | output | DATA_W | Left port read data, zero when not driven |
| l_drive | output | 1 | Left port output-drive flag |
| r_addr | input | ADDR_W | Right port word address |
| r_wdata | input | DATA_W | Right port write data |
| r_rnw | input | 1 | Right port: 1 = read, 0 = write |
| r_en_n | input | 1 | Right port active-low enable |
| r_en | input | 1 | Right port active-high enable |
| r_oe_n | input | 1 | Right port active-low output enable (asynchronous) |
| r_rdata | output | DATA_W | Right port read data, zero when not driven |
| r_drive | output | 1 | Right port output-drive flag |

## Verification
The whole array is first filled from both ports at once, with address-dependent patterns. Scattered reads on both ports then separate correct address decoding from stale or shifted data. Each port is driven with the following patterns, and each one exposes a specific fault:
- **Every disallowed enable combination with a write request:** catches a select decoder that accepts the wrong polarity.
- **Read, write, read sequences:** expose a missing output gap.
- **Idle-then-read sequences in pipelined mode:** show whether the re-arm cycle is honoured.
- **Same-address traffic, one port reading while the other writes, and both ports writing together:** separates read-before-write ordering and left priority from their opposites.
- **Toggling the output enable between clock edges:** confirms that it acts without a clock edge.

// File: rtl/dpsram_pkg.sv
`timescale 1ns/1ps
package dpsram_pkg;

    localparam int NPORT = 2;   // index 0 = left, index 1 = right

    typedef enum logic {
        PATH_FLOW = 1'b0,
        PATH_PIPE = 1'b1
    } read_path_e;

    function automatic logic port_selected(input logic en_lo, input logic en_hi);
        return (!en_lo) && en_hi;
    endfunction

endpackage

// File: rtl/dpsram_array.sv
`timescale 1ns/1ps
module dpsram_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 9,
    parameter int NPORT  = 2
) (
    input  logic                           clk,
    input  logic [NPORT-1:0]               we,
    input  logic [NPORT-1:0][ADDR_W-1:0]   addr,
    input  logic [NPORT-1:0][DATA_W-1:0]   wdata,
    output logic [NPORT-1:0][DATA_W-1:0]   rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0]             mem [DEPTH];
    logic [NPORT-1:0][DATA_W-1:0]  rdata_q;

    // Reads capture the contents present before this edge's writes.
    // Writes are applied from the highest index down, so index 0 (left)
    // lands last and wins a same-address collision.
    always_ff @(posedge clk) begin
        for (int p = 0; p < NPORT; p++) begin
            rdata_q[p] <= mem[addr[p]];
        end
        for (int p = NPORT - 1; p >= 0; p--) begin
            if (we[p]) begin
                mem[addr[p]] <= wdata[p];
            end
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/dpsram_port_ctl.sv
`timescale 1ns/1ps
module dpsram_port_ctl
    import dpsram_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              path_pipe,
    input  logic              en_lo,
    input  logic              en_hi,
    input  logic              rnw,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic              wr_en,
    output logic [DATA_W-1:0] dout,
    output logic              drive
);

    typedef struct packed {
        logic              awake;     // selected at the previous edge
        logic              s1_vld;    // read captured at the last edge
        logic              s1_pv;     // same read, qualified for the pipelined path
        logic              s2_vld;    // pipelined output valid
        logic [DATA_W-1:0] s2_data;   // pipelined output word
    } port_state_t;

    port_state_t       st_d, st_q;
    read_path_e        path;
    logic              sel;
    logic              rd;
    logic              vld;
    logic [DATA_W-1:0] data;

    always_comb begin
        path  = path_pipe ? PATH_PIPE : PATH_FLOW;
        sel   = port_selected(en_lo, en_hi);
        rd    = sel && rnw;
        wr_en = sel && !rnw;

        st_d         = st_q;
        st_d.awake   = sel;
        st_d.s1_vld  = rd;
        st_d.s1_pv   = rd && st_q.awake;
        st_d.s2_vld  = st_q.s1_pv;
        st_d.s2_data = arr_rdata;

        case (path)
            PATH_PIPE: begin
                vld  = st_q.s2_vld;
                data = st_q.s2_data;
            end
            default: begin
                vld  = st_q.s1_vld;
                data = arr_rdata;
            end
        endcase

        drive = vld && !oe_n;
        dout  = drive ? data : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dpsram_core.sv
`timescale 1ns/1ps
module dpsram_core
    import dpsram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe_mode,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    input  logic              l_rnw,
    input  logic              l_en_n,
    input  logic              l_en,
    input  logic              l_oe_n,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_drive,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    input  logic              r_rnw,
    input  logic              r_en_n,
    input  logic              r_en,
    input  logic              r_oe_n,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_drive
);

    logic [NPORT-1:0][ADDR_W-1:0] addr_v;
    logic [NPORT-1:0][DATA_W-1:0] wdata_v;
    logic [NPORT-1:0][DATA_W-1:0] arr_rdata_v;
    logic [NPORT-1:0][DATA_W-1:0] dout_v;
    logic [NPORT-1:0]             rnw_v, en_n_v, en_v, oe_n_v, we_v, drive_v;

    assign addr_v  = {r_addr,  l_addr};
    assign wdata_v = {r_wdata, l_wdata};
    assign rnw_v   = {r_rnw,   l_rnw};
    assign en_n_v  = {r_en_n,  l_en_n};
    assign en_v    = {r_en,    l_en};
    assign oe_n_v  = {r_oe_n,  l_oe_n};

    dpsram_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .NPORT  (NPORT)
    ) u_array (
        .clk   (clk),
        .we    (we_v),
        .addr  (addr_v),
        .wdata (wdata_v),
        .rdata (arr_rdata_v)
    );

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        dpsram_port_ctl #(
            .DATA_W (DATA_W)
        ) u_ctl (
            .clk       (clk),
            .rst_n     (rst_n),
            .path_pipe (pipe_mode),
            .en_lo     (en_n_v[g]),
            .en_hi     (en_v[g]),
            .rnw       (rnw_v[g]),
            .oe_n      (oe_n_v[g]),
            .arr_rdata (arr_rdata_v[g]),
            .wr_en     (we_v[g]),
            .dout      (dout_v[g]),
            .drive     (drive_v[g])
        );
    end

    assign l_rdata = dout_v[0];
    assign r_rdata = dout_v[1];
    assign l_drive = drive_v[0];
    assign r_drive = drive_v[1];

endmodule

// File: rtl/dpsram_core_chk.sv
`timescale 1ns/1ps
module dpsram_core_chk #(
    parameter int DATA_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pipe_mode,
    input logic              l_rnw,
    input logic              l_en_n,
    input logic              l_en,
    input logic              l_oe_n,
    input logic [DATA_W-1:0] l_rdata,
    input logic              l_drive,
    input logic              r_rnw,
    input logic              r_en_n,
    input logic              r_en,
    input logic              r_oe_n,
    input logic [DATA_W-1:0] r_rdata,
    input logic              r_drive
);

    // Counts edges since reset release so history never reaches into reset.
    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm_q <= '0;
        end else if (warm_q != 2'd3) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    logic l_sel, l_rd, r_sel, r_rd, warm;
    assign l_sel = !l_en_n && l_en;
    assign l_rd  = l_sel && l_rnw;
    assign r_sel = !r_en_n && r_en;
    assign r_rd  = r_sel && r_rnw;
    assign warm  = (warm_q == 2'd3);

    AST_L_OE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        l_oe_n |-> !l_drive);                                               // R5
    AST_R_OE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        r_oe_n |-> !r_drive);                                               // R5
    AST_L_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !l_drive |-> (l_rdata == '0));                                      // R11
    AST_R_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !r_drive |-> (r_rdata == '0));                                      // R11
    AST_L_FLOW_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !pipe_mode && !$past(l_rd)) |-> !l_drive);                 // R7
    AST_R_FLOW_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !pipe_mode && !$past(r_rd)) |-> !r_drive);                 // R7
    AST_L_PIPE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && pipe_mode && !$past(l_rd, 2)) |-> !l_drive);               // R1
    AST_L_FLOW_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !pipe_mode && $past(l_rd) && !l_oe_n) |-> l_drive);        // R3
    AST_R_FLOW_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !pipe_mode && $past(r_rd) && !r_oe_n) |-> r_drive);        // R3
    AST_L_PIPE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && pipe_mode && $past(l_rd, 2) && $past(l_sel, 3) && !l_oe_n) |-> l_drive); // R4
    AST_R_PIPE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && pipe_mode && $past(r_rd, 2) && $past(r_sel, 3) && !r_oe_n) |-> r_drive); // R4
    AST_L_PIPE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && pipe_mode && !$past(l_sel, 3)) |-> !l_drive);              // R6
    AST_R_PIPE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && pipe_mode && !$past(r_sel, 3)) |-> !r_drive);              // R6

endmodule

bind dpsram_core dpsram_core_chk #(
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pipe_mode (pipe_mode),
    .l_rnw     (l_rnw),
    .l_en_n    (l_en_n),
    .l_en      (l_en),
    .l_oe_n    (l_oe_n),
    .l_rdata   (l_rdata),
    .l_drive   (l_drive),
    .r_rnw     (r_rnw),
    .r_en_n    (r_en_n),
    .r_en      (r_en),
    .r_oe_n    (r_oe_n),
    .r_rdata   (r_rdata),
    .r_drive   (r_drive)
);

// File: tb/dpsram_core_test.sv
`timescale 1ns/1ps
module dpsram_core_test;

    localparam int AW = 8;
    localparam int DW = 9;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic           rst_n = 1'b0;
    logic           pipe_mode = 1'b0;
    logic [AW-1:0]  addr_i  [2];
    logic [DW-1:0]  wdata_i [2];
    logic           rnw_i   [2];
    logic           en_n_i  [2];
    logic           en_i    [2];
    logic           oe_n_i  [2];
    logic [DW-1:0]  rdata_o [2];
    logic           drive_o [2];

    dpsram_core #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode),
        .l_addr(addr_i[0]), .l_wdata(wdata_i[0]), .l_rnw(rnw_i[0]),
        .l_en_n(en_n_i[0]), .l_en(en_i[0]), .l_oe_n(oe_n_i[0]),
        .l_rdata(rdata_o[0]), .l_drive(drive_o[0]),
        .r_addr(addr_i[1]), .r_wdata(wdata_i[1]), .r_rnw(rnw_i[1]),
        .r_en_n(en_n_i[1]), .r_en(en_i[1]), .r_oe_n(oe_n_i[1]),
        .r_rdata(rdata_o[1]), .r_drive(drive_o[1])
    );

    int    total = 0;
    int    bad   = 0;
    bit    done  = 0;
    string cur_req = "R10";

    // behavioural reference
    int mem_m [256];
    int cur_d [2];
    int prev_d [2];
    bit cur_fv [2];
    bit cur_pv [2];
    bit prev_pv [2];
    bit awake_m [2];

    function automatic int pat(int i);
        return (i * 37 + 5) & 'h1FF;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        if (!rst_n) begin
            for (int p = 0; p < 2; p++) begin
                cur_fv[p] = 0; cur_pv[p] = 0; prev_pv[p] = 0; awake_m[p] = 0;
                cur_d[p] = 0; prev_d[p] = 0;
            end
        end else begin
            for (int p = 0; p < 2; p++) begin
                bit sel;
                sel = !en_n_i[p] && en_i[p];
                prev_pv[p] = cur_pv[p];
                prev_d[p]  = cur_d[p];
                cur_fv[p]  = sel && rnw_i[p];
                cur_d[p]   = mem_m[addr_i[p]];
                cur_pv[p]  = cur_fv[p] && awake_m[p];
                awake_m[p] = sel;
            end
            // right first, then left: left data survives a collision (R9)
            for (int p = 1; p >= 0; p--) begin
                if (!en_n_i[p] && en_i[p] && !rnw_i[p]) mem_m[addr_i[p]] = int'(wdata_i[p]);
            end
        end
    endtask

    task automatic compare();
        for (int p = 0; p < 2; p++) begin
            bit v;
            int d;
            v = (pipe_mode ? prev_pv[p] : cur_fv[p]) && !oe_n_i[p];
            d = v ? (pipe_mode ? prev_d[p] : cur_d[p]) : 0;
            chk(cur_req, p == 0 ? "l_drive" : "r_drive", int'(drive_o[p]), int'(v));
            chk(cur_req, p == 0 ? "l_rdata" : "r_rdata", int'(rdata_o[p]), d);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic idle_p(int p);
        en_n_i[p] = 1'b1; en_i[p] = 1'b0; rnw_i[p] = 1'b1; oe_n_i[p] = 1'b0;
        addr_i[p] = '0; wdata_i[p] = '0;
    endtask

    task automatic rd_p(int p, int a);
        en_n_i[p] = 1'b0; en_i[p] = 1'b1; rnw_i[p] = 1'b1; oe_n_i[p] = 1'b0;
        addr_i[p] = AW'(a);
    endtask

    task automatic wr_p(int p, int a, int d);
        en_n_i[p] = 1'b0; en_i[p] = 1'b1; rnw_i[p] = 1'b0; oe_n_i[p] = 1'b0;
        addr_i[p] = AW'(a); wdata_i[p] = DW'(d);
    endtask

    task automatic do_reset(bit mode);
        rst_n = 1'b0;
        pipe_mode = mode;
        idle_p(0); idle_p(1);
        cur_req = "R10";
        repeat (3) cyc();
        chk("R10", "l_drive in reset", int'(drive_o[0]), 0);
        chk("R10", "r_drive in reset", int'(drive_o[1]), 0);
        rst_n = 1'b1;
        cyc();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle_p(0); idle_p(1);
        do_reset(1'b0);

        // R2: fill whole array from both ports at once
        cur_req = "R2";
        for (int i = 0; i < 128; i++) begin
            wr_p(0, i, pat(i)); wr_p(1, i + 128, pat(i + 128));
            cyc();
        end
        idle_p(0); idle_p(1); cyc();

        // R3: flow-through reads, scattered addresses
        cur_req = "R3";
        rd_p(0, 5); cyc();
        chk("R3", "flow l_drive", int'(drive_o[0]), 1);
        chk("R3", "flow l_rdata", int'(rdata_o[0]), pat(5));
        for (int i = 0; i < 16; i++) begin
            rd_p(0, (i * 13) % 256); rd_p(1, (i * 7 + 200) % 256);
            cyc();
        end
        idle_p(0); idle_p(1); cyc();

        // R1: write attempts with each disallowed enable pair
        cur_req = "R1";
        wr_p(0, 10, 0); en_n_i[0] = 1'b1; en_i[0] = 1'b1; cyc();
        wr_p(0, 11, 0); en_n_i[0] = 1'b0; en_i[0] = 1'b0; cyc();
        wr_p(0, 12, 0); en_n_i[0] = 1'b1; en_i[0] = 1'b0; cyc();
        rd_p(0, 10); en_n_i[0] = 1'b1; cyc();
        chk("R1", "deselected read l_drive", int'(drive_o[0]), 0);
        rd_p(0, 10); cyc();
        chk("R1", "unwritten l_rdata @10", int'(rdata_o[0]), pat(10));
        rd_p(0, 11); cyc();
        rd_p(0, 12); cyc();
        chk("R1", "unwritten l_rdata @12", int'(rdata_o[0]), pat(12));

        // R5 / R11: asynchronous output enable
        cur_req = "R5";
        rd_p(1, 60); cyc();
        oe_n_i[1] = 1'b1; #1;
        chk("R5", "r_drive after oe_n rise", int'(drive_o[1]), 0);
        chk("R11", "r_rdata while floating", int'(rdata_o[1]), 0);
        oe_n_i[1] = 1'b0; #1;
        chk("R5", "r_rdata after oe_n fall", int'(rdata_o[1]), pat(60));
        rd_p(1, 61); oe_n_i[1] = 1'b1; cyc();
        idle_p(1);

        // R7: read-write-read gap, flow-through
        cur_req = "R7";
        rd_p(0, 20); cyc();
        wr_p(0, 21, 'h0C3); cyc();
        chk("R7", "flow gap l_drive", int'(drive_o[0]), 0);
        chk("R11", "flow gap l_rdata", int'(rdata_o[0]), 0);
        rd_p(0, 21); cyc();
        chk("R2", "written word @21", int'(rdata_o[0]), 'h0C3);

        // R8: cross-port read of a word being written
        cur_req = "R8";
        wr_p(0, 30, 'h0AA); rd_p(1, 30); cyc();
        chk("R8", "same-edge r_rdata old", int'(rdata_o[1]), pat(30));
        idle_p(0); rd_p(1, 30); cyc();
        chk("R8", "next-edge r_rdata new", int'(rdata_o[1]), 'h0AA);

        // R9: simultaneous writes to one address
        cur_req = "R9";
        wr_p(0, 40, 'h111); wr_p(1, 40, 'h0EE); cyc();
        idle_p(0); rd_p(1, 40); cyc();
        chk("R9", "collision winner", int'(rdata_o[1]), 'h111);
        idle_p(1); cyc();

        // pipelined path
        do_reset(1'b1);
        cur_req = "R6";
        rd_p(0, 50); cyc();
        rd_p(0, 51); cyc();
        chk("R6", "wake read l_drive", int'(drive_o[0]), 0);
        rd_p(0, 52); cyc();
        chk("R4", "pipe l_rdata @51", int'(rdata_o[0]), pat(51));
        chk("R4", "pipe l_drive", int'(drive_o[0]), 1);
        idle_p(0); cyc();
        rd_p(0, 53); cyc();
        rd_p(0, 54); cyc();
        chk("R6", "re-arm after deselect", int'(drive_o[0]), 0);
        idle_p(0); cyc();

        cur_req = "R4";
        for (int i = 0; i < 16; i++) begin
            rd_p(1, 100 + i); rd_p(0, 255 - i);
            cyc();
        end
        idle_p(0);

        cur_req = "R7";
        rd_p(1, 70); cyc();
        wr_p(1, 71, 'h033); cyc();
        rd_p(1, 71); cyc();
        chk("R7", "pipe gap r_drive", int'(drive_o[1]), 0);
        rd_p(1, 72); cyc();
        chk("R4", "pipe r_rdata @71", int'(rdata_o[1]), 'h033);
        idle_p(1); cyc(); cyc();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule